// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single pulse-width command into two gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. It does not use fixed dead-time delays. Each handover waits for sensed feedback from the power stage. The low side turns on only after the switch node has been seen to fall. The high side turns on only after the low-side gate has been seen to discharge. This keeps the two switches from conducting together, and it keeps body-diode conduction time short.

Two situations would stall that handshake, and each has a timer. With negative inductor current the switch node never falls after the high side opens. A watchdog then turns the low side on anyway so that the current can recirculate, and it pulses a flag when it does so. If the low-side gate never reads as discharged, a second timeout parks the stage with both gates off and latches a fault. Only disabling the block clears that fault.

The high-side on-time is capped at a programmable fraction of the switching period. A separate permission input keeps the low side off, for example during a soft start over a pre-charged output. The low side is never driven before the high side has switched at least once after the block leaves idle. Timing is counted in clock cycles. The switching period, the duty fraction and both timeouts are parameters.

Top module: `adt_gate_seq`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `hs_on`, `ls_on`, `wd_fired` and `fault` are all 0.
- R2: After the high-side enable drops, `ls_on` rises exactly one cycle after the first cycle in which `sw_low` is sampled high. `sw_low` is high when the switch node is low. It never rises earlier.
- R3: When a new high-side pulse is requested, `ls_on` drops first. `hs_on` then rises exactly one cycle after the first cycle in which `lg_low` is sampled high. `lg_low` is high when the low-side gate is discharged.
- R4: If `sw_low` stays low for WD_CYC consecutive waiting cycles (default 16), `ls_on` is forced on with `wd_fired` high for exactly that one first cycle. If `sw_low` arrives in the last waiting cycle, it takes priority and `wd_fired` stays 0.
- R5: If `lg_low` stays low for LG_TMO consecutive waiting cycles (default 12), both enables go to 0 and `fault` becomes 1. `fault` holds while `en` stays high. If `lg_low` arrives in the last waiting cycle, it takes priority and no fault is raised.
- R6: `hs_on` stays high for at most MAX_ON = PERIOD_CLKS*DUTY_PCT/100 consecutive cycles (default 16 of 20, which is 80 %). After a forced cut, `hs_on` does not return until `pwm_cmd` has been low for at least one cycle.
- R7: While `en` is low, both enables are 0 from the next cycle on and `fault` clears. After `en` returns high with `pwm_cmd` high and `lg_low` high, `hs_on` rises on the second sample.
- R8: While `ls_permit` is low, `ls_on` is 0 from the next cycle on. After the high side releases, the block returns to idle without driving the low side.
- R9: `hs_on` and `ls_on` are never both 1 in the same cycle.
- R10: From idle, a rising `pwm_cmd` with `lg_low` already high produces `hs_on` on the second sample. The low side is not driven before that first high-side pulse.
- R11: When `pwm_cmd` falls while `hs_on` is high, `hs_on` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low forces both gates off and clears a fault |
| ls_permit | input | 1 | Permission to drive the low side |
| pwm_cmd | input | 1 | Pulse-width command; high requests the high side |
| sw_low | input | 1 | Sensed flag: switch node has fallen |
| lg_low | input | 1 | Sensed flag: low-side gate is discharged |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| wd_fired | output | 1 | One-cycle pulse when the watchdog forces the low side |
| fault | output | 1 | Latched low-gate discharge timeout |

## Verification
The watchdog expiry and a genuine switch-node fall can land in the same cycle. The same is true of the discharge timeout and a late `lg_low`. The bench models the power stage as delayed sense flags and sweeps each delay across the whole timeout window, including the delay that puts the sensed edge exactly in the last counted cycle. For every delay it computes the expected handover latency and the expected flag or fault value arithmetically. This confirms that the sensed edge wins the tie, and that one cycle more makes the timer win.

// File: rtl/adt_pkg.sv
package adt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_LG = 3'd1,
    ST_HS      = 3'd2,
    ST_WAIT_SW = 3'd3,
    ST_LS      = 3'd4,
    ST_FAULT   = 3'd5
  } adt_state_e;

endpackage

// File: rtl/adt_rst_sync.sv
module adt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/adt_dwell_cnt.sv
module adt_dwell_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = restart || (count != {CNT_W{1'b1}});
    count_d = restart ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= count_d;
  end

endmodule

// File: rtl/adt_duty_gate.sv
module adt_duty_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic limit_hit,
  output logic pwm_req
);

  logic blocked_q;
  logic blocked_d;

  always_comb begin
    blocked_d = pwm_cmd && (blocked_q || limit_hit);
    pwm_req   = pwm_cmd && !blocked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked_q <= 1'b0;
    else        blocked_q <= blocked_d;
  end

endmodule

// File: rtl/adt_seq_fsm.sv
module adt_seq_fsm
  import adt_pkg::*;
#(
  parameter int MAX_ON = 16,
  parameter int WD_CYC = 16,
  parameter int LG_TMO = 12,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pwm_cmd,
  input  logic             pwm_req,
  input  logic             ls_permit,
  input  logic             sw_low,
  input  logic             lg_low,
  input  logic [CNT_W-1:0] count,
  output logic             restart,
  output logic             limit_hit,
  output logic             hs_on,
  output logic             ls_on,
  output logic             wd_fired,
  output logic             fault
);

  localparam logic [CNT_W-1:0] ON_LAST = CNT_W'(MAX_ON - 1);
  localparam logic [CNT_W-1:0] WD_LAST = CNT_W'(WD_CYC - 1);
  localparam logic [CNT_W-1:0] LG_LAST = CNT_W'(LG_TMO - 1);

  adt_state_e state_q;
  adt_state_e state_d;
  logic       wd_q;
  logic       wd_d;
  logic       on_hit;
  logic       wd_hit;
  logic       lg_hit;

  always_comb begin
    on_hit  = (count == ON_LAST);
    wd_hit  = (count == WD_LAST);
    lg_hit  = (count == LG_LAST);
    state_d = state_q;
    wd_d    = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pwm_req) state_d = ST_WAIT_LG;
        end
        ST_WAIT_LG: begin
          if (lg_low)      state_d = pwm_req ? ST_HS : ST_IDLE;
          else if (lg_hit) state_d = ST_FAULT;
        end
        ST_HS: begin
          if (!pwm_cmd || on_hit) state_d = ST_WAIT_SW;
        end
        ST_WAIT_SW: begin
          if (!ls_permit) begin
            state_d = ST_IDLE;
          end else if (sw_low) begin
            state_d = ST_LS;
          end else if (wd_hit) begin
            state_d = ST_LS;
            wd_d    = 1'b1;
          end
        end
        ST_LS: begin
          if (pwm_req || !ls_permit) state_d = ST_WAIT_LG;
        end
        ST_FAULT: begin
          state_d = ST_FAULT;
        end
        default: state_d = ST_IDLE;
      endcase
    end
    restart   = (state_d != state_q);
    limit_hit = en && pwm_cmd && (state_q == ST_HS) && on_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wd_q    <= wd_d;
    end
  end

  assign hs_on    = (state_q == ST_HS);
  assign ls_on    = (state_q == ST_LS);
  assign fault    = (state_q == ST_FAULT);
  assign wd_fired = wd_q;

endmodule

// File: rtl/adt_gate_seq.sv
module adt_gate_seq #(
  parameter int PERIOD_CLKS = 20,
  parameter int DUTY_PCT    = 80,
  parameter int WD_CYC      = 16,
  parameter int LG_TMO      = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ls_permit,
  input  logic pwm_cmd,
  input  logic sw_low,
  input  logic lg_low,
  output logic hs_on,
  output logic ls_on,
  output logic wd_fired,
  output logic fault
);

  localparam int MAX_ON  = (PERIOD_CLKS * DUTY_PCT) / 100;
  localparam int MAX_A   = (MAX_ON > WD_CYC) ? MAX_ON : WD_CYC;
  localparam int CNT_MAX = (MAX_A > LG_TMO) ? MAX_A : LG_TMO;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             srst_n;
  logic             restart;
  logic             limit_hit;
  logic             pwm_req;
  logic [CNT_W-1:0] count;

  adt_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  adt_dwell_cnt #(.CNT_W(CNT_W)) dwell_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .restart (restart),
    .count   (count)
  );

  adt_duty_gate duty_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .pwm_cmd   (pwm_cmd),
    .limit_hit (limit_hit),
    .pwm_req   (pwm_req)
  );

  adt_seq_fsm #(
    .MAX_ON (MAX_ON),
    .WD_CYC (WD_CYC),
    .LG_TMO (LG_TMO),
    .CNT_W  (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .en        (en),
    .pwm_cmd   (pwm_cmd),
    .pwm_req   (pwm_req),
    .ls_permit (ls_permit),
    .sw_low    (sw_low),
    .lg_low    (lg_low),
    .count     (count),
    .restart   (restart),
    .limit_hit (limit_hit),
    .hs_on     (hs_on),
    .ls_on     (ls_on),
    .wd_fired  (wd_fired),
    .fault     (fault)
  );

endmodule

// File: rtl/adt_gate_seq_chk.sv
module adt_gate_seq_chk #(
  parameter int MAX_ON = 16
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ls_permit,
  input logic pwm_cmd,
  input logic sw_low,
  input logic lg_low,
  input logic hs_on,
  input logic ls_on,
  input logic wd_fired,
  input logic fault
);

  logic [15:0] hs_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hs_run_q <= '0;
    else if (!hs_on)                  hs_run_q <= '0;
    else if (hs_run_q != 16'hffff)    hs_run_q <= hs_run_q + 1'b1;
  end

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  a_r2_ls_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> ($past(sw_low) || wd_fired));

  a_r3_hs_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(lg_low));

  a_r4_wd_drives_ls: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fired |-> (ls_on && !$past(sw_low)));

  a_r4_wd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fired |=> !wd_fired);

  a_r5_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!hs_on && !ls_on));

  a_r5_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en) |=> fault);

  a_r6_max_on: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on |-> (hs_run_q < 16'(MAX_ON)));

  a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_on && !ls_on && !fault));

  a_r8_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_permit |=> !ls_on);

  a_r11_cmd_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on && !pwm_cmd) |=> !hs_on);

endmodule

bind adt_gate_seq adt_gate_seq_chk #(.MAX_ON(MAX_ON)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .ls_permit (ls_permit),
  .pwm_cmd   (pwm_cmd),
  .sw_low    (sw_low),
  .lg_low    (lg_low),
  .hs_on     (hs_on),
  .ls_on     (ls_on),
  .wd_fired  (wd_fired),
  .fault     (fault)
);

// File: tb/adt_gate_seq_tb_top.sv
module adt_gate_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_CLKS = 20;
  localparam int DUTY_PCT    = 80;
  localparam int WD_CYC      = 16;
  localparam int LG_TMO      = 12;
  localparam int MAX_ON      = (PERIOD_CLKS * DUTY_PCT) / 100;
  localparam int NEVER       = 1000;

  logic clk = 1'b0;
  logic rst_n, en, ls_permit, pwm_cmd, sw_low, lg_low;
  logic hs_on, ls_on, wd_fired, fault;

  int checks = 0;
  int fails  = 0;
  int sw_dly, lg_dly, hs_off_n, ls_off_n;
  bit overlap_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adt_gate_seq #(
    .PERIOD_CLKS (PERIOD_CLKS),
    .DUTY_PCT    (DUTY_PCT),
    .WD_CYC      (WD_CYC),
    .LG_TMO      (LG_TMO)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ls_permit (ls_permit),
    .pwm_cmd   (pwm_cmd),
    .sw_low    (sw_low),
    .lg_low    (lg_low),
    .hs_on     (hs_on),
    .ls_on     (ls_on),
    .wd_fired  (wd_fired),
    .fault     (fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one sample point; the stage model reacts to the enables just seen
  task automatic tick();
    @(negedge clk);
    if (hs_on && ls_on) overlap_seen = 1'b1;
    if (hs_on) hs_off_n = 0; else if (hs_off_n < NEVER) hs_off_n++;
    if (ls_on) ls_off_n = 0; else if (ls_off_n < NEVER) ls_off_n++;
    sw_low = !hs_on && (hs_off_n > sw_dly);
    lg_low = !ls_on && (ls_off_n > lg_dly);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwm_cmd = 1'b0; en = 1'b1; ls_permit = 1'b1;
    sw_dly = 0; lg_dly = 0; hs_off_n = NEVER; ls_off_n = NEVER;
    sw_low = 1'b1; lg_low = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic start_hs(output int n);
    pwm_cmd = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!hs_on && n < 20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, s, k, e_val, bad, rises;
    logic prev;

    // R1 reset state
    rst_n = 1'b0; pwm_cmd = 1'b1; en = 1'b1; ls_permit = 1'b1;
    sw_low = 1'b1; lg_low = 1'b1; sw_dly = 0; lg_dly = 0;
    hs_off_n = NEVER; ls_off_n = NEVER;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {hs_on, ls_on, wd_fired, fault}, 0);
    pwm_cmd = 1'b0;
    rst_n = 1'b1;
    tick();
    chk("R1 outputs after release", {hs_on, ls_on, wd_fired, fault}, 0);

    // R6 / R10 / R11 on-time sweep
    for (int len = 1; len <= MAX_ON + 2; len++) begin
      do_reset();
      start_hs(n);
      chk("R10 start latency", n, 2);
      s = 1;
      while (hs_on && s < 100) begin
        if (s == len) pwm_cmd = 1'b0;
        tick();
        if (hs_on) s++;
      end
      pwm_cmd = 1'b0;
      chk("R11 R6 high-side run length", s, (len < MAX_ON) ? len : MAX_ON);
    end

    // R6 no re-entry while command stays high
    do_reset();
    start_hs(n);
    rises = 0; prev = hs_on;
    repeat (40) begin
      tick();
      if (hs_on && !prev) rises++;
      prev = hs_on;
    end
    chk("R6 no second pulse while blocked", rises, 0);
    chk("R6 low side holds after cut", ls_on, 1);
    pwm_cmd = 1'b0;
    tick();
    start_hs(n);
    chk("R6 re-arm latency", n, 2);
    pwm_cmd = 1'b0;

    // R2 / R4 switch-node delay sweep across the watchdog window
    for (int i = 0; i <= WD_CYC + 3; i++) begin
      do_reset();
      sw_dly = (i == WD_CYC + 3) ? NEVER : i;
      start_hs(n);
      repeat (3) tick();
      pwm_cmd = 1'b0;
      tick();
      chk("R11 release", hs_on, 0);
      k = 0;
      while (!ls_on && k < 60) begin tick(); k++; end
      e_val = (sw_dly + 1 < WD_CYC) ? sw_dly + 1 : WD_CYC;
      chk("R2 R4 low-side latency", k, e_val);
      chk("R4 watchdog flag", wd_fired, (sw_dly >= WD_CYC) ? 1 : 0);
      tick();
      chk("R4 flag is one cycle", wd_fired, 0);
    end

    // R3 / R5 low-gate delay sweep across the timeout window
    for (int e = 0; e <= LG_TMO + 1; e++) begin
      do_reset();
      lg_dly = e;
      start_hs(n);
      repeat (2) tick();
      pwm_cmd = 1'b0;
      k = 0;
      while (!ls_on && k < 60) begin tick(); k++; end
      repeat (2) tick();
      pwm_cmd = 1'b1;
      k = 0;
      do begin tick(); k++; end while (!hs_on && !fault && k < 60);
      if (e <= LG_TMO - 1) begin
        chk("R3 high-side latency", k, e + 2);
        chk("R5 no fault on sensed edge", fault, 0);
      end else begin
        chk("R5 fault latency", k, LG_TMO + 1);
        chk("R5 fault gates", {fault, hs_on, ls_on}, 3'b100);
        repeat (5) tick();
        chk("R5 fault latched", {fault, hs_on, ls_on}, 3'b100);
        en = 1'b0;
        tick();
        chk("R7 disable clears fault", fault, 0);
        en = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!hs_on && n < 20);
        chk("R7 restart latency", n, 2);
      end
      pwm_cmd = 1'b0;
    end

    // R7 disable while the high side is on
    do_reset();
    start_hs(n);
    tick();
    en = 1'b0;
    tick();
    chk("R7 gates off after disable", {hs_on, ls_on}, 0);
    bad = 0;
    repeat (6) begin tick(); if (hs_on || ls_on) bad++; end
    chk("R7 gates stay off", bad, 0);
    en = 1'b1;
    pwm_cmd = 1'b0;

    // R8 low-side permission
    do_reset();
    ls_permit = 1'b0;
    start_hs(n);
    repeat (2) tick();
    pwm_cmd = 1'b0;
    bad = 0;
    repeat (20) begin tick(); if (ls_on) bad++; end
    chk("R8 low side withheld", bad, 0);
    start_hs(n);
    chk("R8 idle restart latency", n, 2);
    ls_permit = 1'b1;
    pwm_cmd = 1'b0;
    k = 0;
    while (!ls_on && k < 60) begin tick(); k++; end
    chk("R8 low side once permitted", ls_on, 1);
    ls_permit = 1'b0;
    tick();
    chk("R8 permission withdrawn", ls_on, 0);

    // R9 over the whole run
    chk("R9 overlap seen", overlap_seen, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule